// File: doc/BRIEF.md
# Fixed-Width Column Reader

This block streams a range of rows out of a column of fixed-width values in memory. A column lives in two buffers: a data buffer in which row i starts at byte `data_base + i * ELEM_W/8`, and a validity bitmap with one bit per row. A command names a first row and an end row. The block works out which memory words hold those rows and fetches them as bursts on a request/response port. It fetches the matching bitmap words on a second port of the same kind. It then delivers one row per output beat, in ascending order. Each beat carries the element value, a present flag taken from the bitmap, and a last marker.

Inside the block, a word-command generator tells the response aligner two things for every data word: the lane of the first wanted element and how many lanes are wanted. The aligner uses this to pick elements out of each wide word and serialize them. A row counter in the aligner selects the bitmap bit for each row. Memory words are little-endian. Element lane j of a word occupies bits `j*ELEM_W +: ELEM_W`, and bitmap byte k of a word occupies bits `8k+7:8k`.

All streams use valid/ready handshakes. A transfer happens on a rising edge where both valid and ready are high. Once a sender raises valid, it holds valid and its payload unchanged until ready is seen. The output may be stalled at any time by holding `out_ready` low. The memory ports may stall requests, and they may delay responses freely. Responses must come back in request order. Both base addresses must be aligned to the memory word.

Top module: `colrd_top`

## Requirements
- R1: `cmd_ready` is high out of reset and low from the cycle after a non-empty command is accepted. It returns high in the cycle after the beat with `out_last` is transferred, so only one command is in flight.
- R2: A command delivers exactly the rows `cmd_first` to `cmd_last-1`, one beat per row. A command with `cmd_first >= cmd_last` is accepted and produces no beats and no memory requests.
- R3: The beat for row i carries on `out_data` the element stored at byte address `data_base + i*ELEM_W/8`. Beats come out in strictly ascending row order.
- R4: `out_last` is high on the beat for row `cmd_last-1` and low on every other beat.
- R5: `out_present` equals bit i mod 8 (least-significant bit first) of bitmap byte i/8, counted from `bmap_base`. A value of 1 means the row holds a value and 0 means null.
- R6: Data requests carry word-aligned addresses and a length of 1 to MAX_BURST words. Together they cover, in ascending address order and without gaps or overlap, the words from row `cmd_first` to row `cmd_last-1`.
- R7: Bitmap requests follow the rules of R6 on the bitmap buffer. They cover the bitmap words that hold the bits of the requested rows.
- R8: While a valid is high and its ready is low, the sender holds the valid and the payload stable. This applies to `out_*` and to both request ports.
- R9: For each data word, the internal word command has a non-zero count, and its offset plus count does not exceed the number of element lanes in a word. Rows that start in the middle of a word therefore come out correctly.
- R10: After reset, `out_valid`, `dreq_valid` and `breq_valid` are low until a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_base | input | ADDR_W | Byte address of row 0 in the data buffer (word-aligned) |
| bmap_base | input | ADDR_W | Byte address of the validity bitmap (word-aligned) |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high |
| cmd_first | input | IDX_W | First row index |
| cmd_last | input | IDX_W | End row index (exclusive) |
| dreq_valid | output | 1 | Data read request valid |
| dreq_ready | input | 1 | Data read request ready |
| dreq_addr | output | ADDR_W | Data request byte address |
| dreq_len | output | LEN_W | Data request length in words |
| dresp_valid | input | 1 | Data response valid |
| dresp_ready | output | 1 | Data response ready |
| dresp_data | input | WORD_W | Data response word |
| breq_valid | output | 1 | Bitmap read request valid |
| breq_ready | input | 1 | Bitmap read request ready |
| breq_addr | output | ADDR_W | Bitmap request byte address |
| breq_len | output | LEN_W | Bitmap request length in words |
| bresp_valid | input | 1 | Bitmap response valid |
| bresp_ready | output | 1 | Bitmap response ready |
| bresp_data | input | WORD_W | Bitmap response word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat ready |
| out_data | output | ELEM_W | Element value |
| out_present | output | 1 | Validity bit of the row |
| out_last | output | 1 | Beat is the final row of the command |

## Verification
The checker watches several properties on every cycle. It confirms that the command port stays closed while beats are pending and reopens right after the final beat. It confirms that requests are word-aligned with a legal length, and that requests and output beats hold steady under stall. It also keeps every word command inside the lanes of one word. Some properties need a memory model with known contents, so only the bench scenarios can show them. These are that the right element and bitmap bit appear for each row, that `out_last` lands on the final row, and that the request addresses advance over exactly the needed words. The same applies to the handling of empty ranges, ranges that start mid-word, and ranges that cross bitmap-word boundaries.

// File: rtl/colrd_pkg.sv
package colrd_pkg;
  localparam int CNT_W = 8;
  typedef logic [CNT_W-1:0] lane_t;

  // Per data word: first wanted lane and number of wanted lanes.
  typedef struct packed {
    lane_t off;
    lane_t cnt;
  } wcmd_t;
endpackage

// File: rtl/colrd_reqgen.sv
module colrd_reqgen #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 16,
  parameter int RPW        = 2,
  parameter int WORD_BYTES = 8,
  parameter int MAX_BURST  = 4,
  parameter int LEN_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  first,
  input  logic [IDX_W-1:0]  last,
  input  logic [ADDR_W-1:0] base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len
);
  logic             act_q;
  logic [IDX_W-1:0] w_q, wend_q;
  logic [IDX_W:0]   remain;

  assign remain    = {1'b0, wend_q} - {1'b0, w_q} + 1'b1;
  assign req_valid = act_q;
  assign req_len   = (remain > (IDX_W+1)'(MAX_BURST)) ? LEN_W'(MAX_BURST) : LEN_W'(remain);
  assign req_addr  = base + ADDR_W'(w_q) * ADDR_W'(WORD_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      w_q    <= '0;
      wend_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      w_q    <= first / IDX_W'(RPW);
      wend_q <= (last - 1'b1) / IDX_W'(RPW);
    end else if (req_valid && req_ready) begin
      w_q <= w_q + IDX_W'(req_len);
      if (remain <= (IDX_W+1)'(MAX_BURST)) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/colrd_wordcmd.sv
module colrd_wordcmd import colrd_pkg::*; #(
  parameter int IDX_W = 16,
  parameter int EPW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] first,
  input  logic [IDX_W-1:0] last,
  output logic             wc_valid,
  input  logic             wc_ready,
  output wcmd_t            wc
);
  logic             act_q;
  logic [IDX_W-1:0] row_q, last_q, left, room;

  assign left     = last_q - row_q;
  assign room     = IDX_W'(EPW) - (row_q % IDX_W'(EPW));
  assign wc.off   = lane_t'(row_q % IDX_W'(EPW));
  assign wc.cnt   = (left < room) ? lane_t'(left) : lane_t'(room);
  assign wc_valid = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      row_q  <= '0;
      last_q <= '0;
    end else if (start) begin
      act_q  <= 1'b1;
      row_q  <= first;
      last_q <= last;
    end else if (wc_valid && wc_ready) begin
      row_q <= row_q + IDX_W'(wc.cnt);
      if (row_q + IDX_W'(wc.cnt) == last_q) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/colrd_align.sv
module colrd_align import colrd_pkg::*; #(
  parameter int IDX_W  = 16,
  parameter int ELEM_W = 32,
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  first,
  input  logic [IDX_W-1:0]  last,
  input  logic              wc_valid,
  output logic              wc_ready,
  input  wcmd_t             wc,
  input  logic              dresp_valid,
  output logic              dresp_ready,
  input  logic [WORD_W-1:0] dresp_data,
  input  logic              bresp_valid,
  output logic              bresp_ready,
  input  logic [WORD_W-1:0] bresp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ELEM_W-1:0] out_data,
  output logic              out_present,
  output logic              out_last
);
  localparam int BIT_W = $clog2(WORD_W);

  logic [IDX_W-1:0] row_q, last_q;
  lane_t            k_q, lane;
  logic [BIT_W-1:0] bidx;
  logic             fire, word_end;

  assign lane        = wc.off + k_q;
  assign bidx        = row_q[BIT_W-1:0];
  assign out_valid   = wc_valid && dresp_valid && bresp_valid;
  assign out_data    = dresp_data[int'(lane)*ELEM_W +: ELEM_W];
  assign out_present = bresp_data[bidx];
  assign out_last    = (row_q == last_q - 1'b1);
  assign fire        = out_valid && out_ready;
  assign word_end    = (k_q + 1'b1 == wc.cnt);
  assign dresp_ready = fire && word_end;
  assign wc_ready    = fire && word_end;
  assign bresp_ready = fire && ((bidx == {BIT_W{1'b1}}) || out_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q  <= '0;
      last_q <= '0;
      k_q    <= '0;
    end else if (start) begin
      row_q  <= first;
      last_q <= last;
      k_q    <= '0;
    end else if (fire) begin
      row_q <= row_q + 1'b1;
      k_q   <= word_end ? lane_t'(0) : k_q + 1'b1;
    end
  end
endmodule

// File: rtl/colrd_top.sv
module colrd_top import colrd_pkg::*; #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 16,
  parameter int ELEM_W    = 32,
  parameter int WORD_W    = 64,
  parameter int MAX_BURST = 4,
  parameter int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] data_base,
  input  logic [ADDR_W-1:0] bmap_base,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [IDX_W-1:0]  cmd_first,
  input  logic [IDX_W-1:0]  cmd_last,
  output logic              dreq_valid,
  input  logic              dreq_ready,
  output logic [ADDR_W-1:0] dreq_addr,
  output logic [LEN_W-1:0]  dreq_len,
  input  logic              dresp_valid,
  output logic              dresp_ready,
  input  logic [WORD_W-1:0] dresp_data,
  output logic              breq_valid,
  input  logic              breq_ready,
  output logic [ADDR_W-1:0] breq_addr,
  output logic [LEN_W-1:0]  breq_len,
  input  logic              bresp_valid,
  output logic              bresp_ready,
  input  logic [WORD_W-1:0] bresp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ELEM_W-1:0] out_data,
  output logic              out_present,
  output logic              out_last
);
  localparam int EPW        = WORD_W / ELEM_W;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int BRPW       = WORD_W;

  logic  busy_q, start;
  logic  wc_valid, wc_ready;
  wcmd_t wc;

  assign cmd_ready = !busy_q;
  assign start     = cmd_valid && !busy_q && (cmd_first < cmd_last);

  always_ff @(posedge clk) begin
    if (!rst_n)                             busy_q <= 1'b0;
    else if (start)                         busy_q <= 1'b1;
    else if (out_valid && out_ready && out_last) busy_q <= 1'b0;
  end

  colrd_reqgen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .RPW(EPW), .WORD_BYTES(WORD_BYTES),
                 .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)) data_req_i (
    .clk, .rst_n, .start, .first(cmd_first), .last(cmd_last), .base(data_base),
    .req_valid(dreq_valid), .req_ready(dreq_ready), .req_addr(dreq_addr), .req_len(dreq_len));

  colrd_reqgen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .RPW(BRPW), .WORD_BYTES(WORD_BYTES),
                 .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)) bmap_req_i (
    .clk, .rst_n, .start, .first(cmd_first), .last(cmd_last), .base(bmap_base),
    .req_valid(breq_valid), .req_ready(breq_ready), .req_addr(breq_addr), .req_len(breq_len));

  colrd_wordcmd #(.IDX_W(IDX_W), .EPW(EPW)) wordcmd_i (
    .clk, .rst_n, .start, .first(cmd_first), .last(cmd_last),
    .wc_valid, .wc_ready, .wc);

  colrd_align #(.IDX_W(IDX_W), .ELEM_W(ELEM_W), .WORD_W(WORD_W)) align_i (
    .clk, .rst_n, .start, .first(cmd_first), .last(cmd_last),
    .wc_valid, .wc_ready, .wc,
    .dresp_valid, .dresp_ready, .dresp_data,
    .bresp_valid, .bresp_ready, .bresp_data,
    .out_valid, .out_ready, .out_data, .out_present, .out_last);
endmodule

// File: rtl/colrd_sva.sv
module colrd_sva #(
  parameter int ADDR_W    = 32,
  parameter int ELEM_W    = 32,
  parameter int WORD_W    = 64,
  parameter int MAX_BURST = 4,
  parameter int LEN_W     = 3,
  parameter int CNT_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              dreq_valid,
  input logic              dreq_ready,
  input logic [ADDR_W-1:0] dreq_addr,
  input logic [LEN_W-1:0]  dreq_len,
  input logic              breq_valid,
  input logic              breq_ready,
  input logic [ADDR_W-1:0] breq_addr,
  input logic [LEN_W-1:0]  breq_len,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ELEM_W-1:0] out_data,
  input logic              out_present,
  input logic              out_last,
  input logic              wc_valid,
  input logic [CNT_W-1:0]  wc_off,
  input logic [CNT_W-1:0]  wc_cnt
);
  localparam int EPW = WORD_W / ELEM_W;
  localparam int AL  = $clog2(WORD_W / 8);

  // R1: no new command while beats are pending; port reopens after final beat
  assert_busy_closed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cmd_ready);
  assert_reopen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> cmd_ready);

  // R6 / R7: aligned requests of legal length
  assert_dreq_form_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_valid |-> (dreq_addr[AL-1:0] == '0) && (dreq_len != '0) && (int'(dreq_len) <= MAX_BURST));
  assert_breq_form_R7: assert property (@(posedge clk) disable iff (!rst_n)
    breq_valid |-> (breq_addr[AL-1:0] == '0) && (breq_len != '0) && (int'(breq_len) <= MAX_BURST));

  // R8: hold under back-pressure
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_present) && $stable(out_last));
  assert_dreq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_valid && !dreq_ready) |=> dreq_valid && $stable(dreq_addr) && $stable(dreq_len));
  assert_breq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (breq_valid && !breq_ready) |=> breq_valid && $stable(breq_addr) && $stable(breq_len));

  // R9: word command stays within one word
  assert_wcmd_fit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wc_valid |-> (wc_cnt != '0) && (int'(wc_off) + int'(wc_cnt) <= EPW));
endmodule

bind colrd_top colrd_sva #(
  .ADDR_W(ADDR_W), .ELEM_W(ELEM_W), .WORD_W(WORD_W), .MAX_BURST(MAX_BURST),
  .LEN_W(LEN_W), .CNT_W(colrd_pkg::CNT_W)
) sva_i (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
  .dreq_valid(dreq_valid), .dreq_ready(dreq_ready), .dreq_addr(dreq_addr), .dreq_len(dreq_len),
  .breq_valid(breq_valid), .breq_ready(breq_ready), .breq_addr(breq_addr), .breq_len(breq_len),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_present(out_present), .out_last(out_last),
  .wc_valid(wc_valid), .wc_off(wc.off), .wc_cnt(wc.cnt)
);

// File: tb/colrd_top_tb_top.sv
`timescale 1ns/1ps
module colrd_top_tb_top;
  localparam int ADDR_W = 32, IDX_W = 16, ELEM_W = 32, WORD_W = 64, MAXB = 4, LEN_W = 3;
  localparam logic [31:0] DBASE = 32'h0000_1000;
  localparam logic [31:0] BBASE = 32'h0000_8000;
  localparam logic [31:0] NONE  = 32'hFFFF_FFF0;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              cmd_valid = 1'b0, cmd_ready;
  logic [IDX_W-1:0]  cmd_first = '0, cmd_last = '0;
  logic              dreq_valid, dreq_ready, dresp_valid, dresp_ready;
  logic [ADDR_W-1:0] dreq_addr, breq_addr;
  logic [LEN_W-1:0]  dreq_len, breq_len;
  logic [WORD_W-1:0] dresp_data, bresp_data;
  logic              breq_valid, breq_ready, bresp_valid, bresp_ready;
  logic              out_valid, out_ready = 1'b0, out_present, out_last;
  logic [ELEM_W-1:0] out_data;

  int nchk = 0, nfail = 0;
  logic [31:0] dnext = NONE, bnext = NONE;

  colrd_top dut_i (
    .clk, .rst_n, .data_base(DBASE), .bmap_base(BBASE),
    .cmd_valid, .cmd_ready, .cmd_first, .cmd_last,
    .dreq_valid, .dreq_ready, .dreq_addr, .dreq_len, .dresp_valid, .dresp_ready, .dresp_data,
    .breq_valid, .breq_ready, .breq_addr, .breq_len, .bresp_valid, .bresp_ready, .bresp_data,
    .out_valid, .out_ready, .out_data, .out_present, .out_last);

  function automatic logic [31:0] elem(input int r);
    return 32'(r * 3 + 7) ^ 32'h5A00_0000;
  endfunction
  function automatic logic pres(input int r);
    return ((r * 5 + 2) % 7) != 0;
  endfunction
  function automatic logic [63:0] dword(input int w);
    return {elem(2 * w + 1), elem(2 * w)};
  endfunction
  function automatic logic [63:0] bword(input int b);
    logic [63:0] v;
    for (int k = 0; k < 64; k++) v[k] = pres(64 * b + k);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory models: one outstanding request each, responses in order.
  logic dpend = 1'b0, bpend = 1'b0;
  logic [31:0] dptr, bptr;
  int drem, brem;
  assign dreq_ready  = !dpend;
  assign dresp_valid = dpend;
  assign dresp_data  = dword(int'((dptr - DBASE) >> 3));
  assign breq_ready  = !bpend;
  assign bresp_valid = bpend;
  assign bresp_data  = bword(int'((bptr - BBASE) >> 3));

  always @(posedge clk) begin
    if (!rst_n) begin
      dpend <= 1'b0; bpend <= 1'b0;
    end else begin
      if (dreq_valid && dreq_ready) begin
        chk(dreq_addr == dnext, "R6", dreq_addr, dnext);   // R6 contiguous aligned data bursts
        dnext = dnext + 32'(dreq_len) * 8;
        dpend <= 1'b1; dptr <= dreq_addr; drem <= int'(dreq_len);
      end else if (dresp_valid && dresp_ready) begin
        dptr <= dptr + 8; drem <= drem - 1;
        if (drem == 1) dpend <= 1'b0;
      end
      if (breq_valid && breq_ready) begin
        chk(breq_addr == bnext, "R7", breq_addr, bnext);   // R7 contiguous aligned bitmap bursts
        bnext = bnext + 32'(breq_len) * 8;
        bpend <= 1'b1; bptr <= breq_addr; brem <= int'(breq_len);
      end else if (bresp_valid && bresp_ready) begin
        bptr <= bptr + 8; brem <= brem - 1;
        if (brem == 1) bpend <= 1'b0;
      end
    end
  end

  task automatic run_cmd(input int f, input int l, input bit stall);
    int r = f, cyc = 0;
    bit held = 1'b0;
    logic [31:0] hd = '0;
    dnext = (l > f) ? DBASE + 32'((f / 2) * 8)  : NONE;
    bnext = (l > f) ? BBASE + 32'((f / 64) * 8) : NONE;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_first = IDX_W'(f); cmd_last = IDX_W'(l);
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0;
    if (l > f) chk(!cmd_ready, "R1", cmd_ready, 0);      // R1 closed while busy
    while (r < l && cyc < 3000) begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      out_ready = stall ? (cyc % 3 != 0) : 1'b1;
      #1;
      if (held) chk(out_valid && out_data == hd, "R8", out_data, hd);  // R8 held under stall
      held = 1'b0;
      if (out_valid && !out_ready) begin held = 1'b1; hd = out_data; end
      if (out_valid && out_ready) begin
        chk(out_data == elem(r), (f % 2 == 1) ? "R9" : "R3", out_data, elem(r));
        chk(out_present == pres(r), "R5", out_present, pres(r));
        chk(out_last == (r == l - 1), "R4", out_last, (r == l - 1));
        r++;
      end
    end
    chk(r == (l > f ? l : f), "R2", r, (l > f ? l : f));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); out_ready = 1'b1; #1;
      chk(!out_valid, "R2", out_valid, 0);               // R2 no extra beats
    end
    chk(cmd_ready, "R1", cmd_ready, 1);                  // R1 reopened
    out_ready = 1'b0;
  endtask

  // first, last, stall
  localparam int NV = 9;
  localparam int VEC [NV][3] = '{
    '{0, 1, 0}, '{0, 8, 0}, '{3, 10, 1}, '{1, 2, 0}, '{5, 6, 1},
    '{60, 70, 0}, '{7, 20, 1}, '{2, 130, 0}, '{63, 65, 1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    chk(!out_valid, "R10", out_valid, 0);
    chk(!dreq_valid, "R10", dreq_valid, 0);
    chk(!breq_valid, "R10", breq_valid, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cmd_ready, "R1", cmd_ready, 1);
    chk(!out_valid && !dreq_valid && !breq_valid, "R10", {out_valid, dreq_valid, breq_valid}, 0);

    for (int v = 0; v < NV; v++) run_cmd(VEC[v][0], VEC[v][1], VEC[v][2] != 0);

    // R2 corner cases: empty and inverted ranges, then a normal command
    run_cmd(5, 5, 1'b0);
    run_cmd(9, 4, 1'b0);
    run_cmd(4, 7, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule